// File: doc/BRIEF.md
# Lockable Firmware Fetch Route Register

This block is a single 32-bit control register on a simple register bus. A two-bit routing field in it decides where firmware fetch traffic goes: the serial flash interface, the PCI bus or the low pin count bus. The block drives that choice on a one-hot select output, and downstream fetch steering logic uses the select directly.

The field is not fixed at reset. During reset the block loads it from two board strap inputs, which pass through a synchronizer first. After reset, software can rewrite the field through the register port. Each change steers the fetches that follow it.

Software can also set a lock bit. The lock freezes the routing field, and only a reset clears it. The lock does not protect the remaining register bits. They are plain storage and stay writable.

Top module: `boot_route_reg`

## Requirements
- R1: Reset must be held for at least 4 clock cycles. After it is released, a read returns the strap value in bits 11:10, 0 in bit 0 (the lock bit) and 0 in every other bit.
- R2: After reset, changes on the strap inputs have no effect. Neither the routing field nor the route select changes.
- R3: The route select is always one-hot, with bit 0 for serial flash, bit 1 for PCI and bit 2 for the low pin count bus. The field values map as follows: 01 selects serial flash, 10 selects PCI, 11 selects the low pin count bus, and the reserved value 00 also selects serial flash.
- R4: While the lock bit is clear, a write to byte 1 of the register updates bits 11:10. The route select follows starting in the cycle after the write.
- R5: A write with bit 0 set, with byte 0 enabled, sets the lock. After that, writes no longer change bits 11:10 or the route select.
- R6: Software cannot clear the lock by writing 0 to bit 0. Only a reset clears it, and that reset loads the straps again.
- R7: All bits other than 11:10 and 0 are stored and read back as written, whether or not the lock is set.
- R8: Each write updates only the bytes whose byte enable is set (enable bit n covers data bits 8n+7:8n). Disabled bytes keep their values.
- R9: The register decodes at one address. Writes to any other address change nothing, and reads of any other address return 0.
- R10: Read data arrives with a valid pulse one cycle after the read request. When no read was requested, valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are loaded while it is high |
| strap_i | input | 2 | Board strap inputs giving the power-up routing value |
| reg_wr_i | input | 1 | Register write request |
| reg_rd_i | input | 1 | Register read request |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte enables for the write |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| route_sel_o | output | 3 | One-hot fetch destination: [0] flash, [1] PCI, [2] low pin count |

## Verification
The hardest case is a write that arrives after the lock is set and tries to change the routing field, the lock bit and the free storage bits in one write. To reach it, the stimulus first sets the lock. It then issues full-width writes that flip every bit, followed by writes with partial byte enables. The check confirms that only the unprotected bits moved, and that the route select held still. The bench then starts a second reset with different strap values, which shows that the lock and the route really do clear.

// File: rtl/boot_route_pkg.sv
package boot_route_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned BE_W      = REG_W / 8;
    localparam int unsigned FIELD_LSB = 10;
    localparam int unsigned FIELD_W   = 2;
    localparam int unsigned LOCK_BIT  = 0;
    localparam int unsigned NUM_DEST  = 3;

    typedef enum logic [FIELD_W-1:0] {
        RC_RSVD  = 2'b00,
        RC_FLASH = 2'b01,
        RC_PCI   = 2'b10,
        RC_LPC   = 2'b11
    } route_code_e;

    typedef enum int unsigned {
        DEST_FLASH = 0,
        DEST_PCI   = 1,
        DEST_LPC   = 2
    } dest_idx_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             hit;
        logic [REG_W-1:0] wdata;
        logic [BE_W-1:0]  be;
    } reg_req_t;

    function automatic logic [REG_W-1:0] merge_bytes(
        input logic [REG_W-1:0] old_val,
        input logic [REG_W-1:0] new_val,
        input logic [BE_W-1:0]  be
    );
        logic [REG_W-1:0] res;
        res = old_val;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) res[b*8 +: 8] = new_val[b*8 +: 8];
        end
        return res;
    endfunction

    function automatic logic [NUM_DEST-1:0] code_to_sel(input route_code_e code);
        logic [NUM_DEST-1:0] sel;
        sel = '0;
        unique case (code)
            RC_PCI:  sel[DEST_PCI]   = 1'b1;
            RC_LPC:  sel[DEST_LPC]   = 1'b1;
            default: sel[DEST_FLASH] = 1'b1;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/brr_strap_sync.sv
module brr_strap_sync
    import boot_route_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [FIELD_W-1:0] strap_i,
    output route_code_e  code_o
);
    logic [FIELD_W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) stage_q[0] <= strap_i;
            end else begin : g_next
                always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    // rst is intentionally unused for data: the chain must keep sampling during reset
    logic unused_rst;
    assign unused_rst = rst;
    assign code_o = route_code_e'(stage_q[STAGES-1]);
endmodule

// File: rtl/brr_reg_core.sv
module brr_reg_core
    import boot_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  route_code_e      boot_code_i,
    input  reg_req_t         req_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] rdata_o,
    output logic             rvalid_o
);
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] ctrl_d;
    logic [REG_W-1:0] merged;
    logic             locked;

    assign locked = ctrl_q[LOCK_BIT];
    assign merged = merge_bytes(ctrl_q, req_i.wdata, req_i.be);

    always_comb begin
        ctrl_d = ctrl_q;
        if (req_i.wr && req_i.hit) begin
            ctrl_d = merged;
            if (locked) ctrl_d[FIELD_LSB +: FIELD_W] = ctrl_q[FIELD_LSB +: FIELD_W];
            ctrl_d[LOCK_BIT] = locked | merged[LOCK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q                      <= '0;
            ctrl_q[FIELD_LSB +: FIELD_W] <= boot_code_i;
            rdata_o                     <= '0;
            rvalid_o                    <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            rvalid_o <= req_i.rd;
            rdata_o  <= (req_i.rd && req_i.hit) ? ctrl_q : '0;
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/brr_route_decode.sv
module brr_route_decode
    import boot_route_pkg::*;
(
    input  logic [FIELD_W-1:0]  field_i,
    output logic [NUM_DEST-1:0] sel_o
);
    assign sel_o = code_to_sel(route_code_e'(field_i));
endmodule

// File: rtl/boot_route_reg.sv
module boot_route_reg
    import boot_route_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h410,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic [3:0]        reg_be_i,
    output logic [31:0]       reg_rdata_o,
    output logic              reg_rvalid_o,
    output logic [2:0]        route_sel_o
);
    route_code_e      boot_code;
    reg_req_t         req;
    logic [REG_W-1:0] ctrl_q;

    assign req.wr    = reg_wr_i;
    assign req.rd    = reg_rd_i;
    assign req.hit   = (reg_addr_i == REG_ADDR);
    assign req.wdata = reg_wdata_i;
    assign req.be    = reg_be_i;

    brr_strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_i),
        .code_o  (boot_code)
    );

    brr_reg_core u_core (
        .clk         (clk),
        .rst         (rst),
        .boot_code_i (boot_code),
        .req_i       (req),
        .ctrl_o      (ctrl_q),
        .rdata_o     (reg_rdata_o),
        .rvalid_o    (reg_rvalid_o)
    );

    brr_route_decode u_dec (
        .field_i (ctrl_q[FIELD_LSB +: FIELD_W]),
        .sel_o   (route_sel_o)
    );
endmodule

// File: rtl/boot_route_reg_chk.sv
module boot_route_reg_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h410
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_rvalid_o,
    input logic [2:0]        route_sel_o,
    input logic [31:0]       ctrl_q
);
    // R3
    route_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(route_sel_o) == 1);

    // R3
    lpc_select_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[11:10] == 2'b11) |-> route_sel_o[2]);

    // R5
    locked_field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[0] |=> $stable(ctrl_q[11:10]));

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[0] |=> ctrl_q[0]);

    // R2
    no_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_i && reg_addr_i == REG_ADDR) |=> $stable(ctrl_q));

    // R10
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_i |=> reg_rvalid_o);

    // R10
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_i |=> !reg_rvalid_o);
endmodule

bind boot_route_reg boot_route_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_i     (reg_wr_i),
    .reg_rd_i     (reg_rd_i),
    .reg_addr_i   (reg_addr_i),
    .reg_rvalid_o (reg_rvalid_o),
    .route_sel_o  (route_sel_o),
    .ctrl_q       (ctrl_q)
);

// File: tb/boot_route_reg_bench.sv
module boot_route_reg_bench;
    localparam int unsigned ADDR_W = 12;
    localparam logic [ADDR_W-1:0] REG_ADDR = 12'h410;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        strap_i = 2'b01;
    logic              reg_wr_i = 1'b0;
    logic              reg_rd_i = 1'b0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic [31:0]       reg_wdata_i = '0;
    logic [3:0]        reg_be_i = '0;
    logic [31:0]       reg_rdata_o;
    logic              reg_rvalid_o;
    logic [2:0]        route_sel_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [31:0] model;
    typedef struct { logic [31:0] data; string req; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    boot_route_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_boot_route_reg (
        .clk(clk), .rst(rst), .strap_i(strap_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_be_i(reg_be_i),
        .reg_rdata_o(reg_rdata_o), .reg_rvalid_o(reg_rvalid_o),
        .route_sel_o(route_sel_o)
    );

    function automatic logic [2:0] exp_sel(input logic [1:0] f);
        case (f)
            2'b10:   return 3'b010;
            2'b11:   return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pop expected read data whenever valid appears
    always @(negedge clk) begin
        if (!rst && reg_rvalid_o) begin
            if (exp_q.size() == 0) begin
                check("R10", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, reg_rdata_o, e.data);
            end
        end
    end

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        strap_i = s;
        rst = 1'b1;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        model = 32'h0;
        model[11:10] = s;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
        if (a == REG_ADDR) begin
            logic [31:0] m;
            m = model;
            for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = d[b*8 +: 8];
            if (model[0]) m[11:10] = model[11:10];
            m[0] = model[0] | m[0];
            model = m;
        end
        @(negedge clk);
        reg_wr_i = 1'b0; reg_be_i = '0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
        exp_t e;
        @(negedge clk);
        reg_rd_i = 1'b1; reg_addr_i = a;
        e.data = (a == REG_ADDR) ? model : 32'h0;
        e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        reg_rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_route(input string req);
        check(req, {29'b0, route_sel_o}, {29'b0, exp_sel(model[11:10])});
    endtask

    initial begin
        do_reset(2'b01);
        do_read(REG_ADDR, "R1");
        check_route("R3");
        check("R10", {31'b0, reg_rvalid_o}, 32'h0);

        // straps move after reset: ignored
        strap_i = 2'b11;
        repeat (5) @(negedge clk);
        check_route("R2");
        do_read(REG_ADDR, "R2");

        // each field code, unlocked
        for (int c = 0; c < 4; c++) begin
            do_write(REG_ADDR, 32'(c) << 10, 4'b0010);
            check_route("R4");
            check_route("R3");
            do_read(REG_ADDR, "R4");
        end

        // other bits storage and byte enables
        do_write(REG_ADDR, 32'hA5C3_F0FE, 4'b1101);
        do_read(REG_ADDR, "R7");
        do_write(REG_ADDR, 32'h1234_5678, 4'b0100);
        do_read(REG_ADDR, "R8");
        do_write(REG_ADDR, 32'h0000_0800, 4'b0010);
        check_route("R4");

        // wrong address
        do_write(REG_ADDR + 12'h4, 32'hFFFF_FFFF, 4'b1111);
        do_read(REG_ADDR, "R9");
        do_read(REG_ADDR + 12'h4, "R9");
        check_route("R9");

        // set lock together with other bits
        do_write(REG_ADDR, 32'h0000_0801 | 32'h00F0_0000, 4'b0101);
        do_read(REG_ADDR, "R5");
        do_write(REG_ADDR, 32'hFFFF_F7FE, 4'b1111);
        check_route("R5");
        do_read(REG_ADDR, "R5");
        do_write(REG_ADDR, 32'h0000_0000, 4'b0011);
        check_route("R6");
        do_read(REG_ADDR, "R6");
        do_write(REG_ADDR, 32'h5A00_0000, 4'b1000);
        do_read(REG_ADDR, "R7");

        // reset clears lock and reloads straps
        do_reset(2'b10);
        do_read(REG_ADDR, "R6");
        check_route("R6");
        do_write(REG_ADDR, 32'h0000_0C00, 4'b0010);
        check_route("R4");
        do_read(REG_ADDR, "R4");

        do_reset(2'b00);
        check_route("R3");
        do_read(REG_ADDR, "R1");

        repeat (3) @(negedge clk);
        check("R10", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule